// File: doc/BRIEF.md
# Indirect Register Window Controller

This block is the software-facing front end of an I/O interrupt controller. A bus master reaches every internal register through three byte offsets: a select register that names the target, a data window that reads or writes the named 32-bit word, and an end-of-interrupt register. The registers behind the window are an identifier, a version word, an arbitration word and a table of 64-bit routing entries, one per interrupt pin. Each entry is reached as two 32-bit halves.

The routing entries leave the block as a flat vector and go to a separate service engine. That engine drives two status bits back into each entry: a pending-delivery flag and a remote-acknowledge flag. Every accepted table write raises a one-cycle request for the engine to run a new service pass. When the block is built as the newer version, a write to the end-of-interrupt register gives the engine a one-cycle vector strobe.

Top module: `irq_window_ctrl`

## Requirements
- R1: Only the low 8 address bits are decoded. Offset 0x00 is the select register, 0x10 is the data window and 0x40 is the end-of-interrupt register. Every other offset reads 0 and ignores writes, and the end-of-interrupt register reads 0.
- R2: Data-window and end-of-interrupt accesses take effect only when `bus_size` is 4. At any other size the access is ignored and a read returns 0. The select register takes `bus_wdata[7:0]` and reads back zero-extended at any size.
- R3: Select 0x00 (identifier) and select 0x02 (arbitration) both read the 4-bit identifier in bits 27:24. A window write with select 0x00 loads the identifier from `bus_wdata[27:24]`. Window writes with select 0x01 or 0x02 change nothing.
- R4: Select 0x01 reads `VERSION | ((NUM_PINS-1) << 16)`.
- R5: For a select of 0x10 or more, the entry index is (select − 0x10) >> 1. An even select reaches entry bits 31:0 and an odd select reaches bits 63:32. An index of NUM_PINS or more reads 0, ignores writes and raises no service request.
- R6: Entry layout: vector in 7:0, delivery mode in 10:8, destination mode in 11, pending-delivery in 12 (read-only), polarity in 13, remote-acknowledge in 14 (read-only), trigger mode in 15 (1 = level), mask in 16, destination in 63:48. A window write keeps bits 12 and 14 and keeps bits 47:17 at zero.
- R7: After a table write, an entry whose bit 15 is 0 (edge) has bit 14 cleared.
- R8: `service_req` is high for exactly the one cycle after each accepted table write, and is low at all other times.
- R9: When VERSION is 0x20, a 4-byte write to offset 0x40 drives `eoi_valid` high for one cycle after the write, with `eoi_vector` equal to `bus_wdata[7:0]`. When VERSION is 0x11, `eoi_valid` stays 0.
- R10: Reset clears the select register and the identifier, and sets every entry to 0x0000_0000_0001_0000 (masked, all other bits 0).
- R11: A pulse on `svc_rirr_set[i]` sets bit 14 of entry i, and a pulse on `svc_rirr_clr[i]` clears it. Bit 12 of entry i follows `svc_pending[i]` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; only bits 7:0 are decoded |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_size | input | 3 | Access width in bytes |
| bus_rdata | output | 32 | Read data for the current address and size (combinational) |
| svc_rirr_set | input | NUM_PINS | Per-pin set pulse for the remote-acknowledge bit |
| svc_rirr_clr | input | NUM_PINS | Per-pin clear pulse for the remote-acknowledge bit |
| svc_pending | input | NUM_PINS | Per-pin pending-delivery level |
| entries_o | output | 64*NUM_PINS | All routing entries; entry i is in bits 64*i+63 down to 64*i |
| eoi_valid | output | 1 | End-of-interrupt strobe |
| eoi_vector | output | 8 | Vector that goes with the strobe |
| service_req | output | 1 | Request for a new service pass |

## Verification
The bench targets index arithmetic at the edges of the table. It uses the last valid odd select (0x3F, entry 23 high half) and the first select past the table (0x40). A design that computed the index wrongly or left out the range check would write into a neighbour or alias a real entry. The bench also reads the status bits back after the engine has set them and software has rewritten the entry. Writing the whole word without a mask would lose the remote-acknowledge flag, or would let software force bits 12 and 14 and the reserved field. The edge-mode rewrite must clear a flag that is already set, and odd access sizes and the older version must produce no side effects. A design that got these wrong would leave a stale acknowledge, raise a spurious service request or emit a spurious end-of-interrupt strobe.

// File: rtl/iwin_pkg.sv
package iwin_pkg;
  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;
  localparam logic [7:0] OFF_EOI = 8'h40;
  localparam logic [2:0] WORD_BYTES = 3'd4;

  localparam int SEL_W  = 8;
  localparam int IDX_W  = SEL_W - 1;
  localparam logic [SEL_W-1:0] SEL_ID   = 8'h00;
  localparam logic [SEL_W-1:0] SEL_VER  = 8'h01;
  localparam logic [SEL_W-1:0] SEL_ARB  = 8'h02;
  localparam logic [SEL_W-1:0] SEL_TBL  = 8'h10;

  localparam int ID_W   = 4;
  localparam int ID_LSB = 24;

  // entry bit positions used by behaviour
  localparam int B_DSTAT = 12;
  localparam int B_RIRR  = 14;
  localparam int B_TRIG  = 15;
  localparam int B_MASK  = 16;

  localparam logic [63:0] RW_MASK  = 64'hFFFF_0000_0001_AFFF;
  localparam logic [63:0] RO_MASK  = 64'h0000_0000_0000_5000;
  localparam logic [63:0] ENT_RST  = 64'h0000_0000_0001_0000;

  typedef enum logic [1:0] {TGT_NONE, TGT_SEL, TGT_WIN, TGT_EOI} tgt_e;
endpackage

// File: rtl/iwin_decode.sv
module iwin_decode
  import iwin_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  output tgt_e              tgt,
  output logic              size_ok
);
  logic [7:0] off;
  logic       unused_hi;

  assign off       = addr[7:0];
  assign unused_hi = ^addr;
  assign size_ok   = (size == WORD_BYTES);

  always_comb begin
    unique case (off)
      OFF_SEL: tgt = TGT_SEL;
      OFF_WIN: tgt = TGT_WIN;
      OFF_EOI: tgt = TGT_EOI;
      default: tgt = TGT_NONE;
    endcase
  end
endmodule

// File: rtl/iwin_entry.sv
module iwin_entry
  import iwin_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic        rirr_set,
  input  logic        rirr_clr,
  input  logic        pend,
  output logic [63:0] entry_o
);
  logic [63:0] ent_q, ent_d, merged;
  logic        wr_any, en;

  assign wr_any = wr_lo | wr_hi;

  always_comb begin
    merged = ent_q;
    if (wr_lo) merged[31:0]  = wdata;
    if (wr_hi) merged[63:32] = wdata;
    ent_d = ent_q;
    if (wr_any) ent_d = (merged & RW_MASK) | (ent_q & RO_MASK);
    if (wr_any && !ent_d[B_TRIG]) ent_d[B_RIRR] = 1'b0;
    else if (rirr_set)            ent_d[B_RIRR] = 1'b1;
    else if (rirr_clr)            ent_d[B_RIRR] = 1'b0;
    ent_d[B_DSTAT] = pend;
    en = wr_any | rirr_set | rirr_clr | (pend != ent_q[B_DSTAT]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ent_q <= ENT_RST;
    else if (en) ent_q <= ent_d;
  end

  assign entry_o = ent_q;

  assert_rsvd_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ent_q[47:17] == '0);

  assert_edge_rirr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |=> !(!ent_q[B_TRIG] && ent_q[B_RIRR]));
endmodule

// File: rtl/iwin_rdmux.sv
module iwin_rdmux
  import iwin_pkg::*;
#(
  parameter int          NUM_PINS = 24,
  parameter logic [31:0] VER_WORD = 32'h0017_0011
) (
  input  tgt_e              tgt,
  input  logic              size_ok,
  input  logic [SEL_W-1:0]  sel_q,
  input  logic [ID_W-1:0]   id_q,
  input  logic              tbl_hit,
  input  logic [IDX_W-1:0]  idx,
  input  logic              hi,
  input  logic [63:0]       ent_i [NUM_PINS],
  output logic [31:0]       rdata
);
  logic [63:0] pick;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (idx == IDX_W'(i)) pick = ent_i[i];
    end
  end

  always_comb begin
    rdata = '0;
    unique case (tgt)
      TGT_SEL: rdata = 32'(sel_q);
      TGT_WIN: begin
        if (size_ok) begin
          if (sel_q == SEL_ID || sel_q == SEL_ARB) rdata[ID_LSB +: ID_W] = id_q;
          else if (sel_q == SEL_VER)               rdata = VER_WORD;
          else if (tbl_hit)                        rdata = hi ? pick[63:32] : pick[31:0];
        end
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_window_ctrl.sv
module irq_window_ctrl
  import iwin_pkg::*;
#(
  parameter int         ADDR_W   = 12,
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] VERSION  = 8'h11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_wr,
  input  logic [31:0]            bus_wdata,
  input  logic [2:0]             bus_size,
  output logic [31:0]            bus_rdata,
  input  logic [NUM_PINS-1:0]    svc_rirr_set,
  input  logic [NUM_PINS-1:0]    svc_rirr_clr,
  input  logic [NUM_PINS-1:0]    svc_pending,
  output logic [64*NUM_PINS-1:0] entries_o,
  output logic                   eoi_valid,
  output logic [7:0]             eoi_vector,
  output logic                   service_req
);
  localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION};

  tgt_e              tgt;
  logic              size_ok, win_wr;
  logic [SEL_W-1:0]  sel_q, sel_d, rel;
  logic              sel_en;
  logic [ID_W-1:0]   id_q, id_d;
  logic              id_en;
  logic [IDX_W-1:0]  idx;
  logic              hi, tbl_hit, unused_rel0;
  logic [NUM_PINS-1:0] wr_lo, wr_hi;
  logic [63:0]       ent [NUM_PINS];
  logic              svc_q, svc_d;

  iwin_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .size(bus_size), .tgt(tgt), .size_ok(size_ok)
  );

  // select and identifier next state
  assign win_wr      = bus_wr && (tgt == TGT_WIN) && size_ok;
  assign sel_en      = bus_wr && (tgt == TGT_SEL);
  assign sel_d       = bus_wdata[SEL_W-1:0];
  assign id_en       = win_wr && (sel_q == SEL_ID);
  assign id_d        = bus_wdata[ID_LSB +: ID_W];
  assign rel         = sel_q - SEL_TBL;
  assign idx         = rel[SEL_W-1:1];
  assign unused_rel0 = rel[0];
  assign hi          = sel_q[0];
  assign tbl_hit     = (sel_q >= SEL_TBL) && (32'(idx) < NUM_PINS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (sel_en) sel_q <= sel_d;
      if (id_en)  id_q  <= id_d;
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
    assign wr_lo[g] = win_wr && tbl_hit && (idx == IDX_W'(g)) && !hi;
    assign wr_hi[g] = win_wr && tbl_hit && (idx == IDX_W'(g)) &&  hi;
    iwin_entry u_ent (
      .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo[g]), .wr_hi(wr_hi[g]),
      .wdata(bus_wdata), .rirr_set(svc_rirr_set[g]), .rirr_clr(svc_rirr_clr[g]),
      .pend(svc_pending[g]), .entry_o(ent[g])
    );
    assign entries_o[64*g +: 64] = ent[g];
  end

  // service request pulse
  assign svc_d = |(wr_lo | wr_hi);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svc_q <= 1'b0;
    else        svc_q <= svc_d;
  end
  assign service_req = svc_q;

  iwin_rdmux #(.NUM_PINS(NUM_PINS), .VER_WORD(VER_WORD)) u_rd (
    .tgt(tgt), .size_ok(size_ok), .sel_q(sel_q), .id_q(id_q),
    .tbl_hit(tbl_hit), .idx(idx), .hi(hi), .ent_i(ent), .rdata(bus_rdata)
  );

  // end-of-interrupt path exists only in the newer version
  if (VERSION == 8'h20) begin : g_eoi
    logic       eoi_q, eoi_d, vec_en;
    logic [7:0] vec_q;
    assign eoi_d  = bus_wr && (tgt == TGT_EOI) && size_ok;
    assign vec_en = eoi_d;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        eoi_q <= 1'b0;
        vec_q <= '0;
      end else begin
        eoi_q <= eoi_d;
        if (vec_en) vec_q <= bus_wdata[7:0];
      end
    end
    assign eoi_valid  = eoi_q;
    assign eoi_vector = vec_q;

    assert_eoi_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_valid |-> $past(bus_wr && tgt == TGT_EOI && bus_size == 3'd4));
  end else begin : g_no_eoi
    assign eoi_valid  = 1'b0;
    assign eoi_vector = 8'h00;
  end

  assert_svc_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    service_req |-> $past(bus_wr && tgt == TGT_WIN && tbl_hit));

  assert_oob_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_q >= SEL_TBL && !tbl_hit && !(|(wr_lo | wr_hi))) |=> !service_req);

  assert_sel_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr || tgt != TGT_SEL) |=> $stable(sel_q));
endmodule

// File: tb/irq_window_ctrl_test.sv
`timescale 1ns/1ps
module irq_window_ctrl_test;
  localparam int NP = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [2:0] bus_size = 3'd4;
  logic [NP-1:0] rset = '0, rclr = '0, pend = '0;
  logic [31:0] rdata, rdata_old;
  logic [64*NP-1:0] ents, ents_old;
  logic eoi_v, eoi_v_old, svc, svc_old;
  logic [7:0] eoi_vec, eoi_vec_old;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_window_ctrl #(.ADDR_W(12), .NUM_PINS(NP), .VERSION(8'h20)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_size(bus_size), .bus_rdata(rdata),
    .svc_rirr_set(rset), .svc_rirr_clr(rclr), .svc_pending(pend),
    .entries_o(ents), .eoi_valid(eoi_v), .eoi_vector(eoi_vec), .service_req(svc));

  irq_window_ctrl #(.ADDR_W(12), .NUM_PINS(NP), .VERSION(8'h11)) uut_old (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_size(bus_size), .bus_rdata(rdata_old),
    .svc_rirr_set(rset), .svc_rirr_clr(rclr), .svc_pending(pend),
    .entries_o(ents_old), .eoi_valid(eoi_v_old), .eoi_vector(eoi_vec_old),
    .service_req(svc_old));

  // {req[3:0], addr[11:0], size[2:0], wr, wdata[31:0], expect[31:0]}
  localparam int NV = 33;
  localparam logic [83:0] VEC [NV] = '{
    {4'd3, 12'h000, 3'd4, 1'b1, 32'h0000_0000, 32'h0},           // R3 select id
    {4'd3, 12'h010, 3'd4, 1'b1, 32'h0A00_0000, 32'h0},           // R3 load id
    {4'd3, 12'h010, 3'd4, 1'b0, 32'h0,         32'h0A00_0000},   // R3
    {4'd2, 12'h000, 3'd1, 1'b1, 32'h0000_0002, 32'h0},           // R2 select at 1 byte
    {4'd3, 12'h010, 3'd4, 1'b0, 32'h0,         32'h0A00_0000},   // R3 arbitration
    {4'd3, 12'h010, 3'd4, 1'b1, 32'h0500_0000, 32'h0},           // R3 discarded
    {4'd3, 12'h010, 3'd4, 1'b0, 32'h0,         32'h0A00_0000},   // R3
    {4'd4, 12'h000, 3'd4, 1'b1, 32'h0000_0001, 32'h0},           // R4
    {4'd4, 12'h010, 3'd4, 1'b0, 32'h0,         32'h0017_0020},   // R4
    {4'd4, 12'h010, 3'd4, 1'b1, 32'hFFFF_FFFF, 32'h0},           // R4 discarded
    {4'd4, 12'h010, 3'd4, 1'b0, 32'h0,         32'h0017_0020},   // R4
    {4'd5, 12'h000, 3'd4, 1'b1, 32'h0000_0010, 32'h0},           // R5 entry0 low
    {4'd10,12'h010, 3'd4, 1'b0, 32'h0,         32'h0001_0000},   // R10
    {4'd6, 12'h010, 3'd4, 1'b1, 32'hFFFF_FFFF, 32'h0},           // R6
    {4'd6, 12'h010, 3'd4, 1'b0, 32'h0,         32'h0001_AFFF},   // R6
    {4'd1, 12'h110, 3'd4, 1'b0, 32'h0,         32'h0001_AFFF},   // R1 alias
    {4'd2, 12'h010, 3'd2, 1'b0, 32'h0,         32'h0},           // R2
    {4'd2, 12'h010, 3'd1, 1'b1, 32'h0000_0000, 32'h0},           // R2 ignored
    {4'd2, 12'h010, 3'd4, 1'b0, 32'h0,         32'h0001_AFFF},   // R2
    {4'd1, 12'h000, 3'd4, 1'b0, 32'h0,         32'h0000_0010},   // R1 select read
    {4'd1, 12'h020, 3'd4, 1'b0, 32'h0,         32'h0},           // R1 undecoded
    {4'd5, 12'h000, 3'd4, 1'b1, 32'h0000_0011, 32'h0},           // R5 entry0 high
    {4'd6, 12'h010, 3'd4, 1'b1, 32'hDEAD_BEEF, 32'h0},           // R6
    {4'd6, 12'h010, 3'd4, 1'b0, 32'h0,         32'hDEAD_0000},   // R6
    {4'd5, 12'h000, 3'd4, 1'b1, 32'h0000_003F, 32'h0},           // R5 last entry high
    {4'd5, 12'h010, 3'd4, 1'b1, 32'h1234_5678, 32'h0},           // R5
    {4'd5, 12'h010, 3'd4, 1'b0, 32'h0,         32'h1234_0000},   // R5
    {4'd5, 12'h000, 3'd4, 1'b1, 32'h0000_0040, 32'h0},           // R5 out of range
    {4'd5, 12'h010, 3'd4, 1'b1, 32'hFFFF_FFFF, 32'h0},           // R5
    {4'd5, 12'h010, 3'd4, 1'b0, 32'h0,         32'h0},           // R5
    {4'd5, 12'h000, 3'd4, 1'b1, 32'h0000_003E, 32'h0},           // R5 last entry low
    {4'd10,12'h010, 3'd4, 1'b0, 32'h0,         32'h0001_0000},   // R10
    {4'd1, 12'h040, 3'd4, 1'b0, 32'h0,         32'h0}            // R1 eoi reads 0
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = s; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [2:0] s, output logic [31:0] q);
    @(negedge clk);
    bus_addr = a; bus_size = s; bus_wr = 1'b0;
    #1 q = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    rd(12'h000, 3'd4, q); chk("R10 select", q, 32'h0);
    rd(12'h010, 3'd4, q); chk("R10 id", q, 32'h0);
    chk("R10 entry0", ents[31:0], 32'h0001_0000);
    chk("R10 entry23 high", ents[64*23+32 +: 32], 32'h0);
    chk("R10 svc", {31'h0, svc}, 32'h0);
    chk("R10 eoi", {31'h0, eoi_v}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      logic [83:0] v;
      v = VEC[k];
      if (v[64]) wr(v[79:68], v[67:65], v[63:32]);
      else begin
        rd(v[79:68], v[67:65], q);
        chk($sformatf("R%0d vec%0d", v[83:80], k), q, v[31:0]);
      end
    end

    // R4 older version word
    wr(12'h000, 3'd4, 32'h1);
    rd(12'h010, 3'd4, q);
    chk("R4 old version", rdata_old, 32'h0017_0011);

    // R8 service request timing
    wr(12'h000, 3'd4, 32'h14);
    chk("R8 select write no svc", {31'h0, svc}, 32'h0);
    wr(12'h010, 3'd4, 32'h0000_8031);
    chk("R8 svc pulse", {31'h0, svc}, 32'h1);
    @(negedge clk);
    chk("R8 svc drops", {31'h0, svc}, 32'h0);
    wr(12'h010, 3'd2, 32'h0000_8031);
    chk("R8 short write no svc", {31'h0, svc}, 32'h0);

    // R9 end of interrupt
    wr(12'h040, 3'd4, 32'h0000_01C5);
    chk("R9 eoi strobe", {31'h0, eoi_v}, 32'h1);
    chk("R9 eoi vector", {24'h0, eoi_vec}, 32'hC5);
    chk("R9 old version silent", {31'h0, eoi_v_old}, 32'h0);
    @(negedge clk);
    chk("R9 eoi drops", {31'h0, eoi_v}, 32'h0);
    wr(12'h040, 3'd2, 32'h0000_0033);
    chk("R9 short eoi ignored", {31'h0, eoi_v}, 32'h0);

    // R11 status inputs, R6 preservation, R7 edge clear (entry 2 low, select 0x14)
    @(negedge clk); rset = NP'(1) << 2;
    @(negedge clk); rset = '0;
    rd(12'h010, 3'd4, q); chk("R11 rirr set", q, 32'h0000_C031);
    chk("R11 port bit", {31'h0, ents[64*2+14]}, 32'h1);
    @(negedge clk); pend = NP'(1) << 2;
    @(negedge clk);
    rd(12'h010, 3'd4, q); chk("R11 pending follows", q, 32'h0000_D031);
    wr(12'h010, 3'd4, 32'hFFFF_8031);
    rd(12'h010, 3'd4, q); chk("R6 status kept", q, 32'h0001_D031);
    wr(12'h010, 3'd4, 32'h0000_0031);
    rd(12'h010, 3'd4, q); chk("R7 edge clears rirr", q, 32'h0000_1031);
    @(negedge clk); pend = '0;
    @(negedge clk);
    rd(12'h010, 3'd4, q); chk("R11 pending drops", q, 32'h0000_0031);
    wr(12'h010, 3'd4, 32'h0000_8031);
    @(negedge clk); rset = NP'(1) << 2;
    @(negedge clk); rset = '0; rclr = NP'(1) << 2;
    @(negedge clk); rclr = '0;
    rd(12'h010, 3'd4, q); chk("R11 rirr clear", q, 32'h0000_8031);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule